// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one channel of a direct memory access engine. Once software has set up a source base address, a destination base address, an item count and a mode word through a small write-only register port, the channel copies data items from source to destination on its own. Every item costs one read and one write on a simple memory-mapped master port. The channel asks for the system bus before each item and gives it back after it, so the processor gets the bus between items (cycle stealing).

Two pacing schemes are offered. In peripheral-paced operation, each request pulse from the attached device moves one item, and the channel answers with an acknowledge pulse. In memory-to-memory operation, the channel runs freely until the count is used up. Two sticky event flags, half-way and complete, feed a single interrupt line through per-event enables. A circular option reloads the count and both addresses at the end of a pass and keeps the channel enabled. This option is ignored in memory-to-memory operation.

Top module: `dma_xfer_chan`

## Requirements
- R1: With memory-to-memory mode off and the channel enabled, each `periph_req` pulse given while no earlier request is pending moves exactly one item and produces a one-cycle `periph_ack` when that item's write completes. Without requests, no item moves.
- R2: With memory-to-memory mode on (control bit 1), the channel moves all programmed items without any `periph_req`.
- R3: `flag_half` is set when the number of items moved in the current pass reaches floor(count/2). For a count of 1 it is set in the same cycle as `flag_done`.
- R4: `flag_done` is set when the last item of a pass has been written. With circular mode not in effect, `chan_en` returns to 0 at that point.
- R5: `irq` equals (`flag_half` AND half enable, control bit 5) OR (`flag_done` AND done enable, control bit 6).
- R6: With circular mode on (control bit 2) and memory-to-memory off, the end of a pass reloads the count and both addresses to their programmed bases, and `chan_en` stays 1.
- R7: When control bits 1 and 2 are both set, the channel behaves as non-circular: it moves the count once and then clears `chan_en`.
- R8: `bus_req` is raised before each item. `m_valid` is never high without `bus_gnt`. `bus_req` is low for at least one cycle after each item, so there is one `bus_req` rising edge per item.
- R9: After each item, the source and destination addresses each advance by 4 if their increment bit is set (bit 3 for source, bit 4 for destination), and stay fixed otherwise. The data written equals the data read.
- R10: `flag_half` and `flag_done` stay set until a write to register 4 with a 1 in bit 0 (half) or bit 1 (done).
- R11: While `chan_en` is 1, writes to registers 0 to 3 (source base, destination base, count, control) are ignored.
- R12: Setting the enable bit (control bit 0) while the programmed count is 0 leaves `chan_en` at 0, moves nothing and sets no flag.
- R13: After reset, `chan_en`, both flags, `irq`, `bus_req` and `m_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select: 0 source, 1 destination, 2 count, 3 control, 4 flag clear |
| cfg_wdata | input | 32 | Register write data |
| periph_req | input | 1 | Peripheral request pulse, one item each |
| periph_ack | output | 1 | Item written in peripheral-paced operation |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| m_valid | output | 1 | Master access valid |
| m_wr | output | 1 | Master access is a write |
| m_addr | output | 32 | Master byte address |
| m_wdata | output | 32 | Master write data |
| m_rdata | input | 32 | Master read data |
| m_ready | input | 1 | Master access accepted this cycle |
| chan_en | output | 1 | Channel enabled |
| flag_half | output | 1 | Half-transfer flag |
| flag_done | output | 1 | Transfer-complete flag |
| irq | output | 1 | Interrupt |

## Verification
With grant and ready given at once, an item takes four cycles: one idle cycle, one request cycle, one read cycle and one write cycle. The acknowledge appears in the write cycle, while flags, the enable change and the address step appear one edge later. The bench samples at the falling edge. It waits for the acknowledge count or for `chan_en` to fall, then lets several more cycles pass before it reads flags or the write log. A late result is therefore still caught, and an extra item shows up in the log. Register writes are given a full cycle of their own, so an ignored write can be judged from the addresses of the next item.

// File: rtl/dma_chan_pkg.sv
// Package: shared types and control-word bit positions for the DMA channel.
// Assumes the control register is written as one word from cfg_wdata.
package dma_chan_pkg;

    // Control word bit positions (software-visible layout)
    localparam int CTL_EN   = 0;
    localparam int CTL_M2M  = 1;
    localparam int CTL_CIRC = 2;
    localparam int CTL_SINC = 3;
    localparam int CTL_DINC = 4;
    localparam int CTL_HIE  = 5;
    localparam int CTL_DIE  = 6;

    // Register select codes
    localparam logic [2:0] REG_SRC = 3'd0;
    localparam logic [2:0] REG_DST = 3'd1;
    localparam logic [2:0] REG_CNT = 3'd2;
    localparam logic [2:0] REG_CTL = 3'd3;
    localparam logic [2:0] REG_CLR = 3'd4;

    typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RD, ST_WR} seq_st_t;

    typedef struct packed {
        logic done_ie;
        logic half_ie;
        logic dst_inc;
        logic src_inc;
        logic circ;
        logic m2m;
    } chan_mode_t;

endpackage

// File: rtl/dma_cfg_regs.sv
// Module: configuration registers, enable bit, sticky event flags and interrupt.
// Assumes AW and CNT_W are no larger than the 32-bit write data.
// Configuration writes are locked out while the channel is enabled; flag clears are not.
module dma_cfg_regs
    import dma_chan_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    input  logic             ev_half,
    input  logic             ev_done,
    output logic             start,
    output logic [AW-1:0]    base_src,
    output logic [AW-1:0]    base_dst,
    output logic [CNT_W-1:0] count,
    output chan_mode_t       mode_eff,
    output logic             chan_en,
    output logic             flag_half,
    output logic             flag_done,
    output logic             irq
);

    chan_mode_t mode_q;
    logic       wr_ok;
    logic       clr_wr;

    assign wr_ok  = cfg_we && !chan_en;
    assign clr_wr = cfg_we && (cfg_addr == REG_CLR);
    assign start  = wr_ok && (cfg_addr == REG_CTL) && cfg_wdata[CTL_EN] && (count != '0);

    // Effective mode: circular is dropped when memory-to-memory is chosen
    always_comb begin
        mode_eff      = mode_q;
        mode_eff.circ = mode_q.circ && !mode_q.m2m;
    end

    // Hold the programmed configuration, writable only while disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_src <= '0;
            base_dst <= '0;
            count    <= '0;
            mode_q   <= '0;
        end else if (wr_ok) begin
            if (cfg_addr == REG_SRC) base_src <= cfg_wdata[AW-1:0];
            if (cfg_addr == REG_DST) base_dst <= cfg_wdata[AW-1:0];
            if (cfg_addr == REG_CNT) count    <= cfg_wdata[CNT_W-1:0];
            if (cfg_addr == REG_CTL) begin
                mode_q.m2m     <= cfg_wdata[CTL_M2M];
                mode_q.circ    <= cfg_wdata[CTL_CIRC];
                mode_q.src_inc <= cfg_wdata[CTL_SINC];
                mode_q.dst_inc <= cfg_wdata[CTL_DINC];
                mode_q.half_ie <= cfg_wdata[CTL_HIE];
                mode_q.done_ie <= cfg_wdata[CTL_DIE];
            end
        end
    end

    // Enable bit: set by a valid start, cleared by a non-circular completion
    always_ff @(posedge clk) begin
        if (!rst_n)                         chan_en <= 1'b0;
        else if (start)                     chan_en <= 1'b1;
        else if (ev_done && !mode_eff.circ) chan_en <= 1'b0;
    end

    // Sticky flags: set by events, cleared by write-one-to-clear; set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_half <= 1'b0;
            flag_done <= 1'b0;
        end else begin
            flag_half <= (flag_half && !(clr_wr && cfg_wdata[0])) || ev_half;
            flag_done <= (flag_done && !(clr_wr && cfg_wdata[1])) || ev_done;
        end
    end

    assign irq = (flag_half && mode_q.half_ie) || (flag_done && mode_q.done_ie);

    p_half_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_half && !(clr_wr && cfg_wdata[0])) |=> flag_half);
    p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_done && !(clr_wr && cfg_wdata[1])) |=> flag_done);
    p_zero_count_noop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_en && count == '0 && !start) |=> !chan_en);
    p_stop_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_done && !mode_q.circ) |=> !chan_en);
    p_circ_keeps_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_done && mode_q.circ && !mode_q.m2m) |=> chan_en);
    p_cfg_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        chan_en |=> ($stable(base_src) && $stable(base_dst) && $stable(count)));

endmodule

// File: rtl/dma_addr_ptr.sv
// Module: one address pointer. Loads its base on start or wrap, and advances
// by STEP after each item when incrementing is selected.
// Assumes load and step can coincide; load wins.
module dma_addr_ptr #(
    parameter int AW   = 32,
    parameter int STEP = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          inc,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] cur
);

    // Current address: reload, advance or hold
    always_ff @(posedge clk) begin
        if (!rst_n)           cur <= '0;
        else if (load)        cur <= base;
        else if (step && inc) cur <= cur + AW'(STEP);
    end

    p_fixed_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !inc && !load) |=> $stable(cur));
    p_inc_ptr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && inc && !load) |=> (cur == $past(cur) + AW'(STEP)));

endmodule

// File: rtl/dma_seq.sv
// Module: item sequencer. Waits for a trigger, requests the bus, performs one
// read and one write, then releases the bus. Counts items and raises events.
// Assumes the arbiter keeps the grant while bus_req stays high.
module dma_seq
    import dma_chan_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chan_en,
    input  chan_mode_t       mode_eff,
    input  logic [CNT_W-1:0] count,
    input  logic             periph_req,
    output logic             periph_ack,
    output logic             bus_req,
    input  logic             bus_gnt,
    input  logic [AW-1:0]    cur_src,
    input  logic [AW-1:0]    cur_dst,
    output logic             m_valid,
    output logic             m_wr,
    output logic [AW-1:0]    m_addr,
    output logic [DW-1:0]    m_wdata,
    input  logic [DW-1:0]    m_rdata,
    input  logic             m_ready,
    output logic             item_end,
    output logic             wrap,
    output logic             ev_half,
    output logic             ev_done
);

    seq_st_t          state;
    logic [CNT_W-1:0] moved;
    logic [CNT_W-1:0] moved_n;
    logic [CNT_W-1:0] half_pt;
    logic             last;
    logic             pending;
    logic             go;
    logic [DW-1:0]    data_q;

    assign go       = (state == ST_IDLE) && chan_en && (mode_eff.m2m || pending);
    assign item_end = (state == ST_WR) && m_ready;
    assign moved_n  = moved + CNT_W'(1);
    assign half_pt  = count >> 1;
    assign last     = (moved_n == count);
    assign ev_done  = item_end && last;
    assign ev_half  = item_end && (half_pt == '0 ? last : (moved_n == half_pt));
    assign wrap     = ev_done && mode_eff.circ;

    assign bus_req    = (state != ST_IDLE);
    assign m_valid    = (state == ST_RD) || (state == ST_WR);
    assign m_wr       = (state == ST_WR);
    assign m_addr     = (state == ST_WR) ? cur_dst : cur_src;
    assign m_wdata    = data_q;
    assign periph_ack = item_end && !mode_eff.m2m;

    // Item state machine: idle, bus request, read, write
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else begin
            case (state)
                ST_IDLE: if (go)               state <= ST_REQ;
                ST_REQ:  if (bus_gnt)          state <= ST_RD;
                ST_RD:   if (m_ready)          state <= ST_WR;
                ST_WR:   if (m_ready)          state <= ST_IDLE;
                default:                       state <= ST_IDLE;
            endcase
        end
    end

    // Capture read data for the following write
    always_ff @(posedge clk) begin
        if (!rst_n)                          data_q <= '0;
        else if (state == ST_RD && m_ready)  data_q <= m_rdata;
    end

    // Items moved in the current pass; restarts on a pass end or disable
    always_ff @(posedge clk) begin
        if (!rst_n || !chan_en) moved <= '0;
        else if (item_end)      moved <= last ? '0 : moved_n;
    end

    // One outstanding peripheral request; a new pulse in the take cycle is kept
    always_ff @(posedge clk) begin
        if (!rst_n || !chan_en || mode_eff.m2m) pending <= 1'b0;
        else pending <= (pending && !go) || periph_req;
    end

    p_no_access_without_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        m_valid |-> bus_gnt);
    p_bus_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        item_end |=> !bus_req);
    p_ack_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        periph_ack |=> !periph_ack);
    p_no_idle_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !mode_eff.m2m && !pending) |=> !bus_req);
    p_half_with_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_done && count == CNT_W'(1)) |-> ev_half);

endmodule

// File: rtl/dma_xfer_chan.sv
// Module: top of the single-channel DMA engine. Joins the register block,
// two address pointers and the item sequencer.
// Assumes AW <= 32 and an item size of DW/8 bytes.
module dma_xfer_chan
    import dma_chan_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int CNT_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    input  logic          periph_req,
    output logic          periph_ack,
    output logic          bus_req,
    input  logic          bus_gnt,
    output logic          m_valid,
    output logic          m_wr,
    output logic [AW-1:0] m_addr,
    output logic [DW-1:0] m_wdata,
    input  logic [DW-1:0] m_rdata,
    input  logic          m_ready,
    output logic          chan_en,
    output logic          flag_half,
    output logic          flag_done,
    output logic          irq
);

    localparam int ITEM_BYTES = DW / 8;
    localparam int NPTR       = 2;

    logic             start;
    logic             item_end;
    logic             wrap;
    logic             ev_half;
    logic             ev_done;
    logic [AW-1:0]    base_src;
    logic [AW-1:0]    base_dst;
    logic [CNT_W-1:0] count;
    chan_mode_t       mode_eff;
    logic [AW-1:0]    ptr_base [NPTR];
    logic [AW-1:0]    ptr_cur  [NPTR];
    logic             ptr_inc  [NPTR];

    dma_cfg_regs #(.AW(AW), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ev_half   (ev_half),
        .ev_done   (ev_done),
        .start     (start),
        .base_src  (base_src),
        .base_dst  (base_dst),
        .count     (count),
        .mode_eff  (mode_eff),
        .chan_en   (chan_en),
        .flag_half (flag_half),
        .flag_done (flag_done),
        .irq       (irq)
    );

    assign ptr_base[0] = base_src;
    assign ptr_base[1] = base_dst;
    assign ptr_inc[0]  = mode_eff.src_inc;
    assign ptr_inc[1]  = mode_eff.dst_inc;

    // Pointer 0 is the source, pointer 1 the destination
    for (genvar gi = 0; gi < NPTR; gi++) begin : g_ptr
        dma_addr_ptr #(.AW(AW), .STEP(ITEM_BYTES)) u_ptr (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (start || wrap),
            .step  (item_end),
            .inc   (ptr_inc[gi]),
            .base  (ptr_base[gi]),
            .cur   (ptr_cur[gi])
        );
    end

    dma_seq #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_en    (chan_en),
        .mode_eff   (mode_eff),
        .count      (count),
        .periph_req (periph_req),
        .periph_ack (periph_ack),
        .bus_req    (bus_req),
        .bus_gnt    (bus_gnt),
        .cur_src    (ptr_cur[0]),
        .cur_dst    (ptr_cur[1]),
        .m_valid    (m_valid),
        .m_wr       (m_wr),
        .m_addr     (m_addr),
        .m_wdata    (m_wdata),
        .m_rdata    (m_rdata),
        .m_ready    (m_ready),
        .item_end   (item_end),
        .wrap       (wrap),
        .ev_half    (ev_half),
        .ev_done    (ev_done)
    );

    p_irq_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_half || flag_done));
    p_reset_idle_r13: assert property (@(posedge clk)
        !rst_n |=> (!chan_en && !bus_req && !flag_half && !flag_done));

endmodule

// File: tb/sim_dma_xfer_chan.sv
// Bench: table-driven memory-to-memory runs, then directed tests.
module sim_dma_xfer_chan;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        periph_req = 1'b0;
    logic        periph_ack;
    logic        bus_req;
    logic        bus_gnt;
    logic        m_valid;
    logic        m_wr;
    logic [31:0] m_addr;
    logic [31:0] m_wdata;
    logic [31:0] m_rdata;
    logic        m_ready;
    logic        chan_en;
    logic        flag_half;
    logic        flag_done;
    logic        irq;
    logic        gnt_en = 1'b1;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // Write log and event counters
    logic [31:0] log_addr [256];
    logic [31:0] log_data [256];
    int wr_cnt = 0;
    int ack_cnt = 0;
    int rise_cnt = 0;
    logic req_q = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A5A, a[15:0]};
    endfunction

    assign m_rdata = mem_val(m_addr);
    assign m_ready = 1'b1;
    assign bus_gnt = bus_req && gnt_en;

    dma_xfer_chan u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .periph_req(periph_req), .periph_ack(periph_ack),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .m_valid(m_valid), .m_wr(m_wr),
        .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ready(m_ready),
        .chan_en(chan_en), .flag_half(flag_half), .flag_done(flag_done), .irq(irq)
    );

    always @(posedge clk) begin
        if (m_valid && m_wr && m_ready && wr_cnt < 256) begin
            log_addr[wr_cnt] = m_addr;
            log_data[wr_cnt] = m_wdata;
            wr_cnt = wr_cnt + 1;
        end
        if (periph_ack) ack_cnt = ack_cnt + 1;
        if (bus_req && !req_q) rise_cnt = rise_cnt + 1;
        req_q = bus_req;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_req(input int target);
        @(negedge clk);
        periph_req = 1'b1;
        @(negedge clk);
        periph_req = 1'b0;
        for (int k = 0; k < 100 && ack_cnt < target; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_stop();
        for (int k = 0; k < 400 && chan_en; k++) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    // {src, dst, count, control bits}
    localparam logic [87:0] VEC [0:4] = '{
        {32'h0000_1000, 32'h0000_2000, 16'd4, 8'h1A},
        {32'h0000_3000, 32'h0000_4000, 16'd3, 8'h0A},
        {32'h0000_5000, 32'h0000_6000, 16'd5, 8'h12},
        {32'h0000_7000, 32'h0000_8000, 16'd2, 8'h1E},
        {32'h0000_9000, 32'h0000_A000, 16'd1, 8'h1A}
    };

    initial begin
        int b;
        int rb;
        logic [31:0] sa, da;
        do_reset();

        // R13: reset state
        chk(!chan_en && !flag_half && !flag_done, "R13 reset chan/flags", {chan_en, flag_half, flag_done}, 0);
        chk(!irq && !bus_req && !m_valid, "R13 reset irq/bus", {irq, bus_req, m_valid}, 0);

        // Table of memory-to-memory runs
        for (int v = 0; v < 5; v++) begin
            logic [31:0] src, dst;
            logic [15:0] cnt;
            logic [7:0]  md;
            {src, dst, cnt, md} = VEC[v];
            cfg_wr(3'd4, 32'h3);
            b = wr_cnt; rb = rise_cnt;
            cfg_wr(3'd0, src);
            cfg_wr(3'd1, dst);
            cfg_wr(3'd2, {16'd0, cnt});
            cfg_wr(3'd3, {24'd0, md} | 32'h61);
            wait_stop();
            chk(wr_cnt - b == int'(cnt), "R2/R7 item count", wr_cnt - b, cnt);
            for (int i = 0; i < int'(cnt); i++) begin
                sa = md[3] ? src + 32'(4*i) : src;
                da = md[4] ? dst + 32'(4*i) : dst;
                chk(log_addr[b+i] == da, "R9 dest address", log_addr[b+i], da);
                chk(log_data[b+i] == mem_val(sa), "R9 data/source", log_data[b+i], mem_val(sa));
            end
            chk(flag_done && flag_half, "R3/R4 flags after run", {flag_half, flag_done}, 3);
            chk(!chan_en, "R4/R7 enable cleared", chan_en, 0);
            chk(irq, "R5 irq with enables", irq, 1);
            chk(rise_cnt - rb == int'(cnt), "R8 one bus request per item", rise_cnt - rb, cnt);
        end

        // R12: zero count enable is a no-op
        do_reset();
        b = wr_cnt;
        cfg_wr(3'd2, 32'd0);
        cfg_wr(3'd3, 32'h63);
        repeat (20) @(negedge clk);
        chk(!chan_en, "R12 enable stays low", chan_en, 0);
        chk(wr_cnt == b && !flag_half && !flag_done, "R12 no items no flags", wr_cnt - b, 0);

        // Peripheral-paced: R1, R3, R5, R10, R11, R4
        do_reset();
        b = wr_cnt; rb = ack_cnt;
        cfg_wr(3'd0, 32'h100);
        cfg_wr(3'd1, 32'h200);
        cfg_wr(3'd2, 32'd5);
        cfg_wr(3'd3, 32'h39);
        repeat (20) @(negedge clk);
        chk(wr_cnt == b && !bus_req, "R1 no item without request", wr_cnt - b, 0);
        cfg_wr(3'd0, 32'hF00);
        cfg_wr(3'd3, 32'h00);
        chk(chan_en, "R11 control write ignored", chan_en, 1);
        pulse_req(rb + 1);
        chk(wr_cnt - b == 1, "R1 one item per request", wr_cnt - b, 1);
        chk(log_data[b] == mem_val(32'h100), "R11 source base kept", log_data[b], mem_val(32'h100));
        chk(log_addr[b] == 32'h200, "R1 first dest", log_addr[b], 32'h200);
        chk(!flag_half, "R3 half not yet at 1 of 5", flag_half, 0);
        pulse_req(rb + 2);
        chk(flag_half && !flag_done, "R3 half at 2 of 5", {flag_half, flag_done}, 2);
        chk(irq, "R5 irq from half", irq, 1);
        cfg_wr(3'd4, 32'h1);
        chk(!flag_half && !irq, "R10 half cleared by W1C", {flag_half, irq}, 0);
        pulse_req(rb + 3);
        chk(!flag_half, "R10 stays clear", flag_half, 0);
        pulse_req(rb + 4);
        pulse_req(rb + 5);
        chk(flag_done && !irq, "R5 done masked", {flag_done, irq}, 2);
        chk(!chan_en, "R4 enable cleared at end", chan_en, 0);
        chk(wr_cnt - b == 5 && ack_cnt - rb == 5, "R1 five items five acks", wr_cnt - b, 5);
        chk(log_addr[b+4] == 32'h210, "R9 last dest", log_addr[b+4], 32'h210);

        // Circular peripheral mode: R6
        do_reset();
        b = wr_cnt; rb = ack_cnt;
        cfg_wr(3'd0, 32'h400);
        cfg_wr(3'd1, 32'h500);
        cfg_wr(3'd2, 32'd2);
        cfg_wr(3'd3, 32'h5D);
        pulse_req(rb + 1);
        pulse_req(rb + 2);
        chk(flag_done && chan_en, "R6 done with enable kept", {flag_done, chan_en}, 3);
        chk(irq, "R5 irq from done", irq, 1);
        pulse_req(rb + 3);
        chk(wr_cnt - b == 3, "R6 serves after wrap", wr_cnt - b, 3);
        chk(log_addr[b+2] == 32'h500, "R6 dest reloaded", log_addr[b+2], 32'h500);
        chk(log_data[b+2] == mem_val(32'h400), "R6 source reloaded", log_data[b+2], mem_val(32'h400));
        chk(chan_en, "R6 still enabled", chan_en, 1);

        // Grant withheld: R8
        do_reset();
        gnt_en = 1'b0;
        b = wr_cnt;
        cfg_wr(3'd0, 32'hC00);
        cfg_wr(3'd1, 32'hD00);
        cfg_wr(3'd2, 32'd2);
        cfg_wr(3'd3, 32'h1B);
        repeat (20) @(negedge clk);
        chk(bus_req && !m_valid && wr_cnt == b, "R8 waits for grant", {bus_req, m_valid}, 2);
        gnt_en = 1'b1;
        wait_stop();
        chk(wr_cnt - b == 2, "R8 runs after grant", wr_cnt - b, 2);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule